// File: doc/BRIEF.md
# Device Identification Responder for a Two-Wire Serial Bus

This block sits beside the slave logic of a two-wire serial (I2C) device and answers identity queries. A host reads the identity by sending a START, the reserved write address F8h, and then a byte whose upper seven bits name the target device; the low bit of that byte is ignored. After a repeated START it sends the reserved read address F9h. The block then returns a fixed three-byte record: a manufacturer code, a part code and a revision code. The block acknowledges the second byte only when the named address equals its strapped address, so only one device on a shared bus answers.

The block runs on a system clock that is fast compared with SCL. It takes SCL and SDA already filtered, plus one-cycle START and STOP detection pulses. It finds SCL edges itself and drives one output, an active-high pull-down request for SDA. The pull-down is used for acknowledge bits and for the zero bits of the record. If the host keeps acknowledging, the record repeats from the manufacturer byte. The three codes are build-time parameters.

Top module: `devid_responder`

## Requirements
- R1: After reset the SDA pull-down request is deasserted.
- R2: The address byte F8h following a START is acknowledged (pull-down held for the ninth SCL clock). Any address byte other than F8h, or F9h when armed, is not acknowledged.
- R3: After an acknowledged F8h, the next byte is acknowledged when its bits [7:1] equal the strapped 7-bit address, whatever its bit 0 is. On a match the responder becomes armed. A mismatch is not acknowledged.
- R4: After a repeated START, F9h is acknowledged only while armed. Any address byte received disarms the responder, so a second F9h without a new write phase is not acknowledged.
- R5: After the F9h acknowledge, the bytes are sent MSB first in the order manufacturer, part, revision. A transmitted 0 drives the pull-down and a 1 releases it.
- R6: When the host acknowledges the third byte, the next byte sent is the manufacturer byte again, and the cycle continues.
- R7: A NACK (SDA high on the ninth clock after a sent byte) ends the transfer. The pull-down stays released until a new START arrives.
- R8: Every START, including a repeated START, restarts the record at the manufacturer byte.
- R9: After a mismatched device address, a following F9h read is ignored and no data is driven.
- R10: A STOP disarms the responder. An F9h read in a new transaction without a fresh matching write phase is not acknowledged.
- R11: The pull-down request changes only while SCL is low, except at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Filtered SCL level |
| sdaIn | input | 1 | Filtered SDA level |
| startDet | input | 1 | One-cycle pulse on START or repeated START |
| stopDet | input | 1 | One-cycle pulse on STOP |
| ownAddr | input | 7 | Strapped 7-bit slave address of this device |
| sdaPullDown | output | 1 | High requests SDA to be pulled low |

## Verification
The embedded properties check the following on every cycle:
- the pull-down moves only while SCL is low, outside START and STOP;
- a NACK sends the control to idle;
- a STOP leaves it idle and disarmed;
- a START clears the byte index and bit count;
- the index wraps from the revision slot to the manufacturer slot.

Only the directed scenarios can show three things. They show that the whole record comes out in order with the right values and repeats on continued acknowledges. They show that a mismatched device address or a missing write phase leaves the read unanswered. They also show that a fresh START returns the record to its first byte even in the middle of a read.

// File: rtl/devid_pkg.sv
package devid_pkg;
  localparam int BYTE_W       = 8;
  localparam int ID_NUM_BYTES = 3;
  localparam int ID_IDX_W     = $clog2(ID_NUM_BYTES);
  localparam int CNT_W        = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] ID_ADDR_WR = 8'hF8;
  localparam logic [BYTE_W-1:0] ID_ADDR_RD = 8'hF9;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX_ADDR,
    S_ACK_ADDR,
    S_RX_DEV,
    S_ACK_DEV,
    S_TX_BYTE,
    S_TX_ACKCHK
  } rspState_t;

  typedef struct packed {
    logic clrBits;
    logic clrIdx;
    logic loadTx;
    logic shiftTx;
    logic advIdx;
  } dpStrobe_t;
endpackage

// File: rtl/devid_datapath.sv
module devid_datapath
  import devid_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MFG_ID  = 8'h5A,
  parameter logic [BYTE_W-1:0] PART_ID = 8'hC3,
  parameter logic [BYTE_W-1:0] REV_ID  = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  output logic              sclRise,
  output logic              sclFall,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteDone,
  output logic              txBit
);
  localparam logic [ID_NUM_BYTES*BYTE_W-1:0] ID_RECORD = {MFG_ID, PART_ID, REV_ID};
  localparam logic [ID_IDX_W-1:0] LAST_IDX = ID_IDX_W'(ID_NUM_BYTES - 1);
  localparam logic [CNT_W-1:0]    FULL_CNT = CNT_W'(BYTE_W);

  logic                sclQ;
  logic [BYTE_W-1:0]   rxShift;
  logic [BYTE_W-1:0]   txShift;
  logic [CNT_W-1:0]    bitCnt;
  logic [ID_IDX_W-1:0] byteIdx;
  logic [ID_IDX_W-1:0] idxNext;
  logic [BYTE_W-1:0]   idTable [ID_NUM_BYTES];

  genvar g;
  generate
    for (g = 0; g < ID_NUM_BYTES; g++) begin : g_rom
      assign idTable[g] = ID_RECORD[(ID_NUM_BYTES-1-g)*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign rxByte   = rxShift;
  assign byteDone = (bitCnt == FULL_CNT);
  assign txBit    = txShift[BYTE_W-1];

  always_comb begin
    idxNext = byteIdx;
    if (strb.clrIdx)      idxNext = '0;
    else if (strb.advIdx) idxNext = (byteIdx == LAST_IDX) ? '0 : byteIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      rxShift <= '0;
      txShift <= '1;
      bitCnt  <= '0;
      byteIdx <= '0;
    end else begin
      sclQ    <= sclIn;
      byteIdx <= idxNext;
      if (sclRise) rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
      if (strb.clrBits)             bitCnt <= '0;
      else if (sclRise && !byteDone) bitCnt <= bitCnt + 1'b1;
      if (strb.loadTx)       txShift <= idTable[idxNext];
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  // R6: after the last slot the record continues from the first
  p_idx_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advIdx && !strb.clrIdx && byteIdx == LAST_IDX) |=> (byteIdx == '0));

  // R8: a start clears position in the record and the bit count
  p_start_rewind_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrIdx && strb.clrBits) |=> (byteIdx == '0 && bitCnt == '0));
endmodule

// File: rtl/devid_control.sv
module devid_control
  import devid_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [6:0]        ownAddr,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              byteDone,
  output dpStrobe_t         strb,
  output logic              ackDrive,
  output logic              txEnable
);
  rspState_t state, stateN;
  logic armed, armedN;
  logic isRead, isReadN;

  always_comb begin
    stateN  = state;
    armedN  = armed;
    isReadN = isRead;
    strb    = '0;
    if (stopDet) begin
      stateN = S_IDLE;
      armedN = 1'b0;
    end else if (startDet) begin
      stateN       = S_RX_ADDR;
      strb.clrBits = 1'b1;
      strb.clrIdx  = 1'b1;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_RX_ADDR:
          if (sclFall && byteDone) begin
            armedN = 1'b0;
            if (rxByte == ID_ADDR_WR) begin
              stateN  = S_ACK_ADDR;
              isReadN = 1'b0;
            end else if (rxByte == ID_ADDR_RD && armed) begin
              stateN  = S_ACK_ADDR;
              isReadN = 1'b1;
            end else begin
              stateN = S_IDLE;
            end
          end
        S_ACK_ADDR:
          if (sclFall) begin
            strb.clrBits = 1'b1;
            if (isRead) begin
              stateN      = S_TX_BYTE;
              strb.loadTx = 1'b1;
            end else begin
              stateN = S_RX_DEV;
            end
          end
        S_RX_DEV:
          if (sclFall && byteDone) begin
            if (rxByte[BYTE_W-1:1] == ownAddr) begin
              stateN = S_ACK_DEV;
              armedN = 1'b1;
            end else begin
              stateN = S_IDLE;
            end
          end
        S_ACK_DEV:
          if (sclFall) stateN = S_IDLE;
        S_TX_BYTE:
          if (sclFall) begin
            if (byteDone) stateN = S_TX_ACKCHK;
            else          strb.shiftTx = 1'b1;
          end
        S_TX_ACKCHK:
          if (sclRise && sdaIn) begin
            stateN = S_IDLE;
          end else if (sclFall) begin
            stateN       = S_TX_BYTE;
            strb.loadTx  = 1'b1;
            strb.advIdx  = 1'b1;
            strb.clrBits = 1'b1;
          end
        default: stateN = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      armed  <= 1'b0;
      isRead <= 1'b0;
    end else begin
      state  <= stateN;
      armed  <= armedN;
      isRead <= isReadN;
    end
  end

  assign ackDrive = (state == S_ACK_ADDR) || (state == S_ACK_DEV);
  assign txEnable = (state == S_TX_BYTE);

  // R7: a NACK on the ninth clock ends the transfer
  p_nack_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX_ACKCHK && sclRise && sdaIn && !startDet && !stopDet) |=> (state == S_IDLE));

  // R10: a STOP leaves the responder idle and disarmed
  p_stop_disarms_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == S_IDLE && !armed));

  // R4: data is only sent after a read was acknowledged while armed
  p_read_needs_arm_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX_ADDR && stateN == S_ACK_ADDR && isReadN) |-> armed);
endmodule

// File: rtl/devid_responder.sv
module devid_responder
  import devid_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MFG_ID  = 8'h5A,
  parameter logic [BYTE_W-1:0] PART_ID = 8'hC3,
  parameter logic [BYTE_W-1:0] REV_ID  = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [6:0] ownAddr,
  output logic       sdaPullDown
);
  dpStrobe_t         strb;
  logic              sclRise, sclFall, byteDone, txBit;
  logic              ackDrive, txEnable;
  logic [BYTE_W-1:0] rxByte;

  devid_datapath #(.MFG_ID(MFG_ID), .PART_ID(PART_ID), .REV_ID(REV_ID)) i_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .sclRise(sclRise), .sclFall(sclFall), .rxByte(rxByte),
    .byteDone(byteDone), .txBit(txBit)
  );

  devid_control i_ctl (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .startDet(startDet), .stopDet(stopDet),
    .ownAddr(ownAddr), .sclRise(sclRise), .sclFall(sclFall), .rxByte(rxByte),
    .byteDone(byteDone), .strb(strb), .ackDrive(ackDrive), .txEnable(txEnable)
  );

  assign sdaPullDown = ackDrive | (txEnable & ~txBit);

  // R11: SDA drive moves only while SCL is low
  p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaPullDown) && !$past(startDet) && !$past(stopDet)) |-> !sclIn);
endmodule

// File: tb/test_devid_responder.sv
module test_devid_responder;
  localparam logic [7:0] E_MFG  = 8'h5A;
  localparam logic [7:0] E_PART = 8'hC3;
  localparam logic [7:0] E_REV  = 8'h01;
  localparam logic [6:0] OWN    = 7'h24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaM = 1'b1;
  logic startDet = 1'b0;
  logic stopDet = 1'b0;
  logic sdaIn;
  logic sdaPullDown;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  assign sdaIn = sdaM & ~sdaPullDown;

  devid_responder #(.MFG_ID(E_MFG), .PART_ID(E_PART), .REV_ID(E_REV)) i_devid_responder (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .startDet(startDet),
    .stopDet(stopDet), .ownAddr(OWN), .sdaPullDown(sdaPullDown)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic early, output logic late);
    sclIn = 1'b0; waitN(2);
    sdaM = b;     waitN(2);
    sclIn = 1'b1; waitN(1);
    early = sdaIn; waitN(2);
    late = sdaIn;  waitN(1);
  endtask

  task automatic busStart();
    sclIn = 1'b0; waitN(2);
    sdaM = 1'b1;  waitN(2);
    sclIn = 1'b1; waitN(2);
    sdaM = 1'b0; startDet = 1'b1; waitN(1);
    startDet = 1'b0; waitN(2);
  endtask

  task automatic busStop();
    sclIn = 1'b0; waitN(2);
    sdaM = 1'b0;  waitN(2);
    sclIn = 1'b1; waitN(2);
    sdaM = 1'b1; stopDet = 1'b1; waitN(1);
    stopDet = 1'b0; waitN(2);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ackd);
    logic e, l;
    for (int i = 7; i >= 0; i--) clockBit(b[i], e, l);
    clockBit(1'b1, e, l);
    ackd = !e;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    logic e, l;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, e, l);
      b[i] = e;
      chk("R11 bit stable while SCL high", {31'd0, l}, {31'd0, e});
    end
    clockBit(!giveAck, e, l);
  endtask

  task automatic armAndRead(input logic [7:0] devByte);
    logic a;
    busStart();
    writeByte(8'hF8, a);    chk("R2 F8 acknowledged", a, 1);
    writeByte(devByte, a);  chk("R3 own address acknowledged", a, 1);
    busStart();
    writeByte(8'hF9, a);    chk("R4 F9 acknowledged when armed", a, 1);
  endtask

  task automatic tReset();
    chk("R1 pull-down released after reset", sdaPullDown, 0);
  endtask

  task automatic tFullRecord();
    logic [7:0] b;
    armAndRead({OWN, 1'b0});
    readByte(1'b1, b); chk("R5 manufacturer byte", b, E_MFG);
    readByte(1'b1, b); chk("R5 part byte", b, E_PART);
    readByte(1'b1, b); chk("R5 revision byte", b, E_REV);
    readByte(1'b1, b); chk("R6 wrap to manufacturer", b, E_MFG);
    readByte(1'b0, b); chk("R6 part after wrap", b, E_PART);
    sclIn = 1'b0; waitN(3);
    chk("R7 released after NACK", sdaPullDown, 0);
    sclIn = 1'b1; waitN(4);
    chk("R7 still released before STOP", sdaPullDown, 0);
    busStop();
  endtask

  task automatic tRestartRewinds();
    logic [7:0] b;
    armAndRead({OWN, 1'b1});
    readByte(1'b1, b); chk("R3 LSB ignored, manufacturer read", b, E_MFG);
    readByte(1'b0, b); chk("R5 part byte before restart", b, E_PART);
    armAndRead({OWN, 1'b0});
    readByte(1'b0, b); chk("R8 START rewinds to manufacturer", b, E_MFG);
    busStop();
  endtask

  task automatic tMismatch();
    logic a;
    logic [7:0] b;
    busStart();
    writeByte(8'hF8, a);        chk("R2 F8 acknowledged", a, 1);
    writeByte({OWN ^ 7'h01, 1'b0}, a); chk("R3 mismatch not acknowledged", a, 0);
    busStart();
    writeByte(8'hF9, a);        chk("R9 read after mismatch ignored", a, 0);
    readByte(1'b1, b);          chk("R9 no data driven", b, 8'hFF);
    busStop();
  endtask

  task automatic tNoWritePhase();
    logic a;
    busStart();
    writeByte(8'hF9, a);        chk("R4 F9 without arming not acknowledged", a, 0);
    busStop();
    busStart();
    writeByte({OWN, 1'b0}, a);  chk("R2 ordinary address not acknowledged", a, 0);
    busStop();
  endtask

  task automatic tStopDisarms();
    logic a;
    busStart();
    writeByte(8'hF8, a);
    writeByte({OWN, 1'b0}, a);  chk("R3 own address acknowledged", a, 1);
    busStop();
    busStart();
    writeByte(8'hF9, a);        chk("R10 read after STOP not acknowledged", a, 0);
    busStop();
  endtask

  task automatic tReadConsumesArm();
    logic a;
    logic [7:0] b;
    armAndRead({OWN, 1'b0});
    readByte(1'b0, b);          chk("R5 manufacturer byte", b, E_MFG);
    busStart();
    writeByte(8'hF9, a);        chk("R4 second F9 not acknowledged", a, 0);
    busStop();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    waitN(5);
    rstN = 1'b1;
    waitN(3);
    tReset();
    tFullRecord();
    tRestartRewinds();
    tMismatch();
    tNoWritePhase();
    tStopDisarms();
    tReadConsumesArm();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      summary();
    end
  end
endmodule